// File: doc/BRIEF.md
# Execute-Group Redirect Arbiter

This block sits at the execute end of an out-of-order pipeline. Each cycle it accepts a group of up to `W` issued instructions, walks them from the oldest slot upward, and lets at most `E` of them use a functional unit. Instructions that were already cancelled upstream still pass through to commit as done, but they take no functional unit and cannot start a redirect. Every instruction that passes is written into a small commit-side buffer that holds `T` rows of `W` cells. Commit reads the oldest row each cycle unless it holds the buffer.

While it walks the group, the block looks for the first event that must redirect the front end. A mispredicted branch gives a branch squash packet. This packet carries the corrected direction, which the block works out from the branch's next PC and its sequential PC (PC + 4). A memory-order violation flag gives a memory squash packet when the instruction reached has no mispredict. Only the first such event in a group is acted on. Two counters record wrong predictions that had been predicted taken, and memory-order squashes.

If the buffer cannot take every result of a group, the block raises a stall and takes nothing from that group. The issuing side must present the group again.

Top module: `exe_redirect_arb`

## Requirements
- R1: After reset, `cm_valid` is all zero, `sq_valid` is 0, both counters are 0 and `grp_stall` is 0.
- R2: Slots are walked from slot 0 (bit 0, oldest) upward. The walk stops at the first slot with `iss_valid` low, after `W` slots, or when `E` functional units are in use. Only slots reached before the stop are forwarded.
- R3: A slot with `iss_squashed` high is forwarded with `cm_squashed` set. It uses no functional unit and never starts a redirect, whatever its mispredict bit or the violation flag says.
- R4: The redirect is taken at the first forwarded, non-squashed slot that is mispredicted or that sees `mem_viol` high. At that slot a mispredict wins over the violation. Every later event in the group is ignored.
- R5: A branch redirect raises `sq_valid` and `sq_is_branch` for exactly one cycle, starting the cycle after the group. It carries that slot's sequence number, PC and next PC.
- R6: `sq_taken` on a branch redirect is 1 exactly when the next PC differs from PC + 4.
- R7: `cnt_taken_wrong` increases by one for each branch redirect whose slot had `iss_pred_taken` set. It is unchanged otherwise.
- R8: A memory redirect raises `sq_valid` with `sq_is_branch` = 0. It carries the slot's sequence number and next PC, `sq_pc` = 0, `sq_taken` = 0, and `sq_viol_seq` = `mem_viol_seq`. It also increases `cnt_viol` by one.
- R9: Forwarded results fill the first free cells of the commit buffer in slot order. The buffer's cells are numbered row by row, and row 0 is what `cm_*` show. When the buffer was empty, a group appears on `cm_*` in the next cycle. Each cycle with `cm_hold` low retires row 0.
- R10: While `cm_hold` is high, row 0 stays on `cm_*` unchanged, and new results queue behind it in up to `T` rows.
- R11: `grp_stall` is high when the group's forwarded count exceeds the cells left free after this cycle's retirement. A stalled group writes nothing, starts no redirect and leaves both counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | W | Slot holds an issued instruction |
| iss_squashed | input | W | Slot's instruction was cancelled upstream |
| iss_mispred | input | W | Slot's branch resolved against its prediction |
| iss_pred_taken | input | W | Slot's branch had been predicted taken |
| iss_pc | input | W*PC_W | Per-slot PC |
| iss_npc | input | W*PC_W | Per-slot resolved next PC |
| iss_seq | input | W*SEQ_W | Per-slot sequence number |
| mem_viol | input | 1 | Memory-order violation reported this cycle |
| mem_viol_seq | input | SEQ_W | Sequence number of the violating load |
| cm_hold | input | 1 | Commit does not take row 0 this cycle |
| grp_stall | output | 1 | Group not accepted; present it again |
| cm_valid | output | W | Row 0 cell occupancy |
| cm_squashed | output | W | Row 0 cell was cancelled upstream |
| cm_seq | output | W*SEQ_W | Row 0 sequence numbers |
| cm_pc | output | W*PC_W | Row 0 PCs |
| sq_valid | output | 1 | Squash packet present |
| sq_is_branch | output | 1 | 1 for branch redirect, 0 for memory redirect |
| sq_taken | output | 1 | Corrected branch direction |
| sq_seq | output | SEQ_W | Sequence number of the redirecting instruction |
| sq_pc | output | PC_W | PC of the mispredicted branch (0 for memory) |
| sq_npc | output | PC_W | Restart PC |
| sq_viol_seq | output | SEQ_W | Violating load's sequence number (memory only) |
| cnt_taken_wrong | output | CNT_W | Count of taken-predicted mispredicts acted on |
| cnt_viol | output | CNT_W | Count of memory-order squashes |

## Verification
Some properties are checked on every cycle. The functional-unit count never exceeds `E`, and at most one slot is picked as the redirect. A stalled group is never followed by a squash packet, and the counters move by at most one. A branch packet's direction always agrees with its PCs, and a memory packet has its PC and direction cleared. While commit holds, row 0 stays put.

Other behaviour needs the bench's scenarios to show it. This covers which slots a walk forwards with gaps and cancelled slots, and which of several events in a group wins. It also covers the exact fields of each packet, the order in which a partially filled row packs results, and proof that a stalled group left no trace in the buffer once it drains.

// File: rtl/exe_redir_pkg.sv
`timescale 1ns/1ps
package exe_redir_pkg;
  localparam int unsigned INSN_BYTES = 4;

  // Corrected branch direction: the resolved next PC is not the sequential one.
  function automatic logic fn_corr_taken(input logic [63:0] pc,
                                         input logic [63:0] npc,
                                         input int unsigned pc_w);
    logic [63:0] mask;
    logic [63:0] seq_pc;
    mask   = (pc_w >= 64) ? '1 : ((64'd1 << pc_w) - 64'd1);
    seq_pc = (pc + 64'(INSN_BYTES)) & mask;
    return (npc & mask) != seq_pc;
  endfunction

  // Buffer fill level once this cycle's oldest row has (or has not) retired.
  function automatic int fn_after_retire(input int occ, input int w, input logic hold);
    if (hold) return occ;
    return (occ > w) ? (occ - w) : 0;
  endfunction
endpackage

// File: rtl/exe_scan.sv
`timescale 1ns/1ps
module exe_scan #(
  parameter int W = 4,
  parameter int E = 2,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  valid,
  input  logic [W-1:0]  squashed,
  output logic [W-1:0]  fwd_mask,
  output logic [W-1:0]  exe_mask,
  output logic [CW-1:0] fwd_cnt
);
  always_comb begin
    int   used;
    logic go;
    used     = 0;
    go       = 1'b1;
    fwd_mask = '0;
    exe_mask = '0;
    fwd_cnt  = '0;
    for (int i = 0; i < W; i++) begin
      if (go && valid[i] && (used < E)) begin
        fwd_mask[i] = 1'b1;
        fwd_cnt     = fwd_cnt + CW'(1);
        if (!squashed[i]) begin
          exe_mask[i] = 1'b1;
          used        = used + 1;
        end
      end else begin
        go = 1'b0;
      end
    end
  end
endmodule

// File: rtl/redirect_pick.sv
`timescale 1ns/1ps
module redirect_pick #(
  parameter int W = 4
) (
  input  logic [W-1:0] exe_mask,
  input  logic [W-1:0] mispred,
  input  logic         mem_viol,
  output logic [W-1:0] hit_mask,
  output logic         hit_any,
  output logic         hit_branch
);
  always_comb begin
    hit_mask   = '0;
    hit_any    = 1'b0;
    hit_branch = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (!hit_any && exe_mask[i] && (mispred[i] || mem_viol)) begin
        hit_mask[i] = 1'b1;
        hit_any     = 1'b1;
        hit_branch  = mispred[i];
      end
    end
  end
endmodule

// File: rtl/wb_buffer.sv
`timescale 1ns/1ps
module wb_buffer
  import exe_redir_pkg::*;
#(
  parameter int W     = 4,
  parameter int T     = 5,
  parameter int PC_W  = 32,
  parameter int SEQ_W = 16,
  localparam int CW    = $clog2(W + 1),
  localparam int CELLS = T * W,
  localparam int OCC_W = $clog2(CELLS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold,
  input  logic               accept,
  input  logic [CW-1:0]      add_cnt,
  input  logic [W*SEQ_W-1:0] in_seq,
  input  logic [W*PC_W-1:0]  in_pc,
  input  logic [W-1:0]       in_sq,
  output logic [OCC_W-1:0]   free_cnt,
  output logic [OCC_W-1:0]   occ_o,
  output logic [W-1:0]       row_valid,
  output logic [W*SEQ_W-1:0] row_seq,
  output logic [W*PC_W-1:0]  row_pc,
  output logic [W-1:0]       row_sq
);
  logic [OCC_W-1:0] occ_q, occ_n, base;
  logic [SEQ_W-1:0] seq_q [CELLS];
  logic [SEQ_W-1:0] seq_n [CELLS];
  logic [PC_W-1:0]  pc_q  [CELLS];
  logic [PC_W-1:0]  pc_n  [CELLS];
  logic [CELLS-1:0] sq_q, sq_n;

  always_comb begin
    base     = OCC_W'(fn_after_retire(int'(occ_q), W, hold));
    free_cnt = OCC_W'(CELLS) - base;
    occ_n    = accept ? (base + OCC_W'(add_cnt)) : base;
  end

  always_comb begin
    for (int j = 0; j < CELLS; j++) begin
      int src;
      src = hold ? j : (j + W);
      if (src < CELLS) begin
        seq_n[j] = seq_q[src];
        pc_n[j]  = pc_q[src];
        sq_n[j]  = sq_q[src];
      end else begin
        seq_n[j] = '0;
        pc_n[j]  = '0;
        sq_n[j]  = 1'b0;
      end
      for (int k = 0; k < W; k++) begin
        if (accept && (k < int'(add_cnt)) && (int'(base) + k == j)) begin
          seq_n[j] = in_seq[k*SEQ_W +: SEQ_W];
          pc_n[j]  = in_pc[k*PC_W +: PC_W];
          sq_n[j]  = in_sq[k];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q <= '0;
      sq_q  <= '0;
      for (int j = 0; j < CELLS; j++) begin
        seq_q[j] <= '0;
        pc_q[j]  <= '0;
      end
    end else begin
      occ_q <= occ_n;
      sq_q  <= sq_n;
      for (int j = 0; j < CELLS; j++) begin
        seq_q[j] <= seq_n[j];
        pc_q[j]  <= pc_n[j];
      end
    end
  end

  assign occ_o = occ_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_row
      assign row_valid[i]                = (i < int'(occ_q));
      assign row_seq[i*SEQ_W +: SEQ_W]   = seq_q[i];
      assign row_pc[i*PC_W +: PC_W]      = pc_q[i];
      assign row_sq[i]                   = sq_q[i] && (i < int'(occ_q));
    end
  endgenerate
endmodule

// File: rtl/exe_redirect_arb.sv
`timescale 1ns/1ps
module exe_redirect_arb
  import exe_redir_pkg::*;
#(
  parameter int W     = 4,
  parameter int E     = 2,
  parameter int T     = 5,
  parameter int PC_W  = 32,
  parameter int SEQ_W = 16,
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [W-1:0]       iss_valid,
  input  logic [W-1:0]       iss_squashed,
  input  logic [W-1:0]       iss_mispred,
  input  logic [W-1:0]       iss_pred_taken,
  input  logic [W*PC_W-1:0]  iss_pc,
  input  logic [W*PC_W-1:0]  iss_npc,
  input  logic [W*SEQ_W-1:0] iss_seq,
  input  logic               mem_viol,
  input  logic [SEQ_W-1:0]   mem_viol_seq,
  input  logic               cm_hold,
  output logic               grp_stall,
  output logic [W-1:0]       cm_valid,
  output logic [W-1:0]       cm_squashed,
  output logic [W*SEQ_W-1:0] cm_seq,
  output logic [W*PC_W-1:0]  cm_pc,
  output logic               sq_valid,
  output logic               sq_is_branch,
  output logic               sq_taken,
  output logic [SEQ_W-1:0]   sq_seq,
  output logic [PC_W-1:0]    sq_pc,
  output logic [PC_W-1:0]    sq_npc,
  output logic [SEQ_W-1:0]   sq_viol_seq,
  output logic [CNT_W-1:0]   cnt_taken_wrong,
  output logic [CNT_W-1:0]   cnt_viol
);
  localparam int CW    = $clog2(W + 1);
  localparam int CELLS = T * W;
  localparam int OCC_W = $clog2(CELLS + 1);

  // Named internal events, also observed by the bound checker.
  logic [W-1:0]     fwd_mask, exe_mask, hit_mask;
  logic [CW-1:0]    fwd_cnt;
  logic             hit_any, hit_branch;
  logic [OCC_W-1:0] wb_free, wb_occ;
  logic             take_redirect;

  exe_scan #(.W(W), .E(E)) u_scan (
    .valid    (iss_valid),
    .squashed (iss_squashed),
    .fwd_mask (fwd_mask),
    .exe_mask (exe_mask),
    .fwd_cnt  (fwd_cnt)
  );

  redirect_pick #(.W(W)) u_pick (
    .exe_mask   (exe_mask),
    .mispred    (iss_mispred),
    .mem_viol   (mem_viol),
    .hit_mask   (hit_mask),
    .hit_any    (hit_any),
    .hit_branch (hit_branch)
  );

  assign grp_stall     = int'(fwd_cnt) > int'(wb_free);
  assign take_redirect = hit_any && !grp_stall;

  wb_buffer #(.W(W), .T(T), .PC_W(PC_W), .SEQ_W(SEQ_W)) u_wb (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (cm_hold),
    .accept    (!grp_stall),
    .add_cnt   (fwd_cnt),
    .in_seq    (iss_seq),
    .in_pc     (iss_pc),
    .in_sq     (iss_squashed & fwd_mask),
    .free_cnt  (wb_free),
    .occ_o     (wb_occ),
    .row_valid (cm_valid),
    .row_seq   (cm_seq),
    .row_pc    (cm_pc),
    .row_sq    (cm_squashed)
  );

  // Fields of the chosen slot.
  logic [SEQ_W-1:0] sel_seq;
  logic [PC_W-1:0]  sel_pc, sel_npc;
  logic             sel_pt, sel_taken;

  always_comb begin
    sel_seq = '0;
    sel_pc  = '0;
    sel_npc = '0;
    sel_pt  = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (hit_mask[i]) begin
        sel_seq = sel_seq | iss_seq[i*SEQ_W +: SEQ_W];
        sel_pc  = sel_pc  | iss_pc[i*PC_W +: PC_W];
        sel_npc = sel_npc | iss_npc[i*PC_W +: PC_W];
        sel_pt  = sel_pt  | iss_pred_taken[i];
      end
    end
    sel_taken = fn_corr_taken(64'(sel_pc), 64'(sel_npc), PC_W);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq_valid        <= 1'b0;
      sq_is_branch    <= 1'b0;
      sq_taken        <= 1'b0;
      sq_seq          <= '0;
      sq_pc           <= '0;
      sq_npc          <= '0;
      sq_viol_seq     <= '0;
      cnt_taken_wrong <= '0;
      cnt_viol        <= '0;
    end else begin
      sq_valid     <= take_redirect;
      sq_is_branch <= take_redirect && hit_branch;
      sq_taken     <= take_redirect && hit_branch && sel_taken;
      sq_seq       <= take_redirect ? sel_seq : '0;
      sq_pc        <= (take_redirect && hit_branch) ? sel_pc : '0;
      sq_npc       <= take_redirect ? sel_npc : '0;
      sq_viol_seq  <= (take_redirect && !hit_branch) ? mem_viol_seq : '0;
      if (take_redirect && hit_branch && sel_pt)
        cnt_taken_wrong <= cnt_taken_wrong + CNT_W'(1);
      if (take_redirect && !hit_branch)
        cnt_viol <= cnt_viol + CNT_W'(1);
    end
  end
endmodule

// File: rtl/exe_redirect_arb_chk.sv
`timescale 1ns/1ps
module exe_redirect_arb_chk #(
  parameter int W     = 4,
  parameter int E     = 2,
  parameter int T     = 5,
  parameter int PC_W  = 32,
  parameter int SEQ_W = 16,
  parameter int CNT_W = 16,
  localparam int CELLS = T * W,
  localparam int OCC_W = $clog2(CELLS + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [W-1:0]       exe_mask,
  input logic [W-1:0]       hit_mask,
  input logic [OCC_W-1:0]   wb_occ,
  input logic               grp_stall,
  input logic               cm_hold,
  input logic [W-1:0]       cm_valid,
  input logic [W*SEQ_W-1:0] cm_seq,
  input logic               sq_valid,
  input logic               sq_is_branch,
  input logic               sq_taken,
  input logic [PC_W-1:0]    sq_pc,
  input logic [PC_W-1:0]    sq_npc,
  input logic [CNT_W-1:0]   cnt_taken_wrong,
  input logic [CNT_W-1:0]   cnt_viol
);
  p_fu_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(exe_mask) <= E);

  p_single_pick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_mask));

  p_taken_rule_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_valid && sq_is_branch) |-> (sq_taken == (sq_npc != (sq_pc + PC_W'(4)))));

  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_taken_wrong - $past(cnt_taken_wrong)) <= CNT_W'(1));

  p_mem_packet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_valid && !sq_is_branch) |-> (sq_pc == '0 && !sq_taken));

  p_viol_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_viol - $past(cnt_viol)) <= CNT_W'(1));

  p_occ_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wb_occ) <= CELLS);

  p_hold_row_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_hold && cm_valid[0]) |=> (cm_valid[0] && $stable(cm_seq[SEQ_W-1:0])));

  p_stall_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    grp_stall |=> !sq_valid);
endmodule

bind exe_redirect_arb exe_redirect_arb_chk #(
  .W(W), .E(E), .T(T), .PC_W(PC_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .exe_mask        (exe_mask),
  .hit_mask        (hit_mask),
  .wb_occ          (wb_occ),
  .grp_stall       (grp_stall),
  .cm_hold         (cm_hold),
  .cm_valid        (cm_valid),
  .cm_seq          (cm_seq),
  .sq_valid        (sq_valid),
  .sq_is_branch    (sq_is_branch),
  .sq_taken        (sq_taken),
  .sq_pc           (sq_pc),
  .sq_npc          (sq_npc),
  .cnt_taken_wrong (cnt_taken_wrong),
  .cnt_viol        (cnt_viol)
);

// File: tb/exe_redirect_arb_bench.sv
`timescale 1ns/1ps
module exe_redirect_arb_bench;
  localparam int W = 4, E = 2, T = 5, PC_W = 32, SEQ_W = 16, CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0]       iss_valid, iss_squashed, iss_mispred, iss_pred_taken;
  logic [W*PC_W-1:0]  iss_pc, iss_npc;
  logic [W*SEQ_W-1:0] iss_seq;
  logic               mem_viol, cm_hold;
  logic [SEQ_W-1:0]   mem_viol_seq;
  logic               grp_stall, sq_valid, sq_is_branch, sq_taken;
  logic [W-1:0]       cm_valid, cm_squashed;
  logic [W*SEQ_W-1:0] cm_seq;
  logic [W*PC_W-1:0]  cm_pc;
  logic [SEQ_W-1:0]   sq_seq, sq_viol_seq;
  logic [PC_W-1:0]    sq_pc, sq_npc;
  logic [CNT_W-1:0]   cnt_taken_wrong, cnt_viol;

  int n_total = 0;
  int n_bad   = 0;

  always #10 clk = ~clk;

  exe_redirect_arb #(.W(W), .E(E), .T(T), .PC_W(PC_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_exe_redirect_arb (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_squashed(iss_squashed), .iss_mispred(iss_mispred),
    .iss_pred_taken(iss_pred_taken), .iss_pc(iss_pc), .iss_npc(iss_npc), .iss_seq(iss_seq),
    .mem_viol(mem_viol), .mem_viol_seq(mem_viol_seq), .cm_hold(cm_hold),
    .grp_stall(grp_stall), .cm_valid(cm_valid), .cm_squashed(cm_squashed),
    .cm_seq(cm_seq), .cm_pc(cm_pc), .sq_valid(sq_valid), .sq_is_branch(sq_is_branch),
    .sq_taken(sq_taken), .sq_seq(sq_seq), .sq_pc(sq_pc), .sq_npc(sq_npc),
    .sq_viol_seq(sq_viol_seq), .cnt_taken_wrong(cnt_taken_wrong), .cnt_viol(cnt_viol)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    iss_valid = '0; iss_squashed = '0; iss_mispred = '0; iss_pred_taken = '0;
    iss_pc = '0; iss_npc = '0; iss_seq = '0; mem_viol = 1'b0; mem_viol_seq = '0;
  endtask

  task automatic put(input int i, input bit sq, input bit mp, input bit pt,
                     input logic [31:0] pc, input logic [31:0] npc, input logic [15:0] seq);
    iss_valid[i] = 1'b1; iss_squashed[i] = sq; iss_mispred[i] = mp; iss_pred_taken[i] = pt;
    iss_pc[i*PC_W +: PC_W] = pc; iss_npc[i*PC_W +: PC_W] = npc; iss_seq[i*SEQ_W +: SEQ_W] = seq;
  endtask

  function automatic logic [15:0] cseq(input int i);
    return cm_seq[i*SEQ_W +: SEQ_W];
  endfunction

  // Direction restated as a PC distance.
  function automatic logic exp_taken(input logic [31:0] pc, input logic [31:0] npc);
    return (npc - pc) != 32'd4;
  endfunction

  task automatic drain();
    clear_in();
    cm_hold = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", "cm_valid", 64'(cm_valid), 64'h0);
    check("R1", "sq_valid", 64'(sq_valid), 64'h0);
    check("R1", "cnt_taken_wrong", 64'(cnt_taken_wrong), 64'h0);
    check("R1", "cnt_viol", 64'(cnt_viol), 64'h0);
    check("R1", "grp_stall", 64'(grp_stall), 64'h0);
  endtask

  task automatic t_fu_limit();
    @(negedge clk);
    for (int i = 0; i < 4; i++) put(i, 0, 0, 0, 32'h100 + 32'(4*i), 32'h104 + 32'(4*i), 16'(10 + i));
    #1 check("R11", "no stall when empty", 64'(grp_stall), 64'h0);
    @(negedge clk);
    check("R2", "E limit stops walk", 64'(cm_valid), 64'h3);
    check("R9", "slot0 seq next cycle", 64'(cseq(0)), 64'd10);
    check("R9", "slot1 seq", 64'(cseq(1)), 64'd11);
    check("R4", "no redirect", 64'(sq_valid), 64'h0);
    drain();
  endtask

  task automatic t_gap();
    @(negedge clk);
    put(0, 1, 0, 0, 32'h200, 32'h204, 16'd20);
    put(1, 0, 0, 0, 32'h204, 32'h208, 16'd21);
    put(3, 0, 0, 0, 32'h20c, 32'h210, 16'd23);
    @(negedge clk);
    check("R2", "empty slot stops walk", 64'(cm_valid), 64'h3);
    check("R3", "squashed flag forwarded", 64'(cm_squashed), 64'h1);
    check("R2", "slot1 seq", 64'(cseq(1)), 64'd21);
    drain();
  endtask

  task automatic t_squashed_free();
    @(negedge clk);
    put(0, 1, 1, 1, 32'h300, 32'h900, 16'd30);
    put(1, 1, 1, 1, 32'h304, 32'h900, 16'd31);
    put(2, 0, 0, 0, 32'h308, 32'h30c, 16'd32);
    put(3, 0, 0, 0, 32'h30c, 32'h310, 16'd33);
    @(negedge clk);
    check("R3", "squashed slots use no FU", 64'(cm_valid), 64'hf);
    check("R3", "squashed flags", 64'(cm_squashed), 64'h3);
    check("R3", "squashed mispredict ignored", 64'(sq_valid), 64'h0);
    check("R3", "counter untouched", 64'(cnt_taken_wrong), 64'h0);
    drain();
  endtask

  task automatic t_branch();
    @(negedge clk);
    put(0, 0, 0, 0, 32'h0ffc, 32'h1000, 16'd40);
    put(1, 0, 1, 1, 32'h1000, 32'h1004, 16'd41);
    @(negedge clk);
    clear_in();
    check("R5", "sq_valid", 64'(sq_valid), 64'h1);
    check("R5", "sq_is_branch", 64'(sq_is_branch), 64'h1);
    check("R5", "sq_seq", 64'(sq_seq), 64'd41);
    check("R5", "sq_pc", 64'(sq_pc), 64'h1000);
    check("R5", "sq_npc", 64'(sq_npc), 64'h1004);
    check("R6", "not taken", 64'(sq_taken), 64'(exp_taken(32'h1000, 32'h1004)));
    check("R7", "taken-wrong count", 64'(cnt_taken_wrong), 64'd1);
    @(negedge clk);
    check("R5", "one cycle only", 64'(sq_valid), 64'h0);
    put(0, 0, 1, 0, 32'h2000, 32'h2040, 16'd42);
    @(negedge clk);
    clear_in();
    check("R6", "taken", 64'(sq_taken), 64'(exp_taken(32'h2000, 32'h2040)));
    check("R7", "not-taken prediction not counted", 64'(cnt_taken_wrong), 64'd1);
    drain();
  endtask

  task automatic t_first_only();
    @(negedge clk);
    put(0, 0, 1, 1, 32'h500, 32'h600, 16'd50);
    put(1, 0, 1, 1, 32'h600, 32'h700, 16'd51);
    @(negedge clk);
    clear_in();
    check("R4", "first mispredict wins", 64'(sq_seq), 64'd50);
    check("R4", "later mispredict ignored by counter", 64'(cnt_taken_wrong), 64'd2);
    drain();
  endtask

  task automatic t_viol();
    @(negedge clk);
    mem_viol = 1'b1; mem_viol_seq = 16'h77;
    put(0, 0, 0, 0, 32'h3000, 32'h3004, 16'd60);
    put(1, 0, 1, 1, 32'h3004, 32'h3100, 16'd61);
    @(negedge clk);
    clear_in();
    check("R8", "memory packet kind", 64'(sq_is_branch), 64'h0);
    check("R4", "violation at earlier slot wins", 64'(sq_seq), 64'd60);
    check("R8", "sq_npc", 64'(sq_npc), 64'h3004);
    check("R8", "sq_pc cleared", 64'(sq_pc), 64'h0);
    check("R8", "sq_viol_seq", 64'(sq_viol_seq), 64'h77);
    check("R8", "cnt_viol", 64'(cnt_viol), 64'd1);
    check("R7", "branch after violation ignored", 64'(cnt_taken_wrong), 64'd2);
    @(negedge clk);
    mem_viol = 1'b1; mem_viol_seq = 16'h78;
    put(0, 0, 1, 0, 32'h4000, 32'h4100, 16'd62);
    @(negedge clk);
    clear_in();
    check("R4", "mispredict beats violation", 64'(sq_is_branch), 64'h1);
    check("R4", "cnt_viol unchanged", 64'(cnt_viol), 64'd1);
    @(negedge clk);
    mem_viol = 1'b1;
    put(0, 1, 0, 0, 32'h5000, 32'h5004, 16'd63);
    @(negedge clk);
    clear_in();
    check("R3", "squashed slot cannot trigger violation", 64'(sq_valid), 64'h0);
    check("R3", "cnt_viol unchanged", 64'(cnt_viol), 64'd1);
    drain();
  endtask

  task automatic t_pack();
    @(negedge clk);
    cm_hold = 1'b1;
    put(0, 0, 0, 0, 32'h0, 32'h4, 16'd300);
    put(1, 0, 0, 0, 32'h4, 32'h8, 16'd301);
    @(negedge clk);
    clear_in();
    put(0, 1, 0, 0, 32'h8, 32'hc, 16'd302);
    put(1, 0, 0, 0, 32'hc, 32'h10, 16'd303);
    put(2, 0, 0, 0, 32'h10, 32'h14, 16'd304);
    @(negedge clk);
    clear_in();
    check("R9", "row0 packed full", 64'(cm_valid), 64'hf);
    check("R9", "cell2 from second group", 64'(cseq(2)), 64'd302);
    check("R9", "cell3", 64'(cseq(3)), 64'd303);
    cm_hold = 1'b0;
    @(negedge clk);
    check("R9", "spill row", 64'(cm_valid), 64'h1);
    check("R9", "spill seq", 64'(cseq(0)), 64'd304);
    drain();
  endtask

  task automatic t_hold_stall();
    cm_hold = 1'b1;
    for (int g = 0; g < T; g++) begin
      @(negedge clk);
      clear_in();
      for (int i = 0; i < W; i++) put(i, 1, 0, 0, 32'h0, 32'h4, 16'(100 + 4*g + i));
      #1 if (g == T - 1) check("R11", "last row fits", 64'(grp_stall), 64'h0);
    end
    @(negedge clk);
    clear_in();
    put(0, 0, 1, 1, 32'h8000, 32'h9000, 16'd200);
    #1 check("R11", "stall when full", 64'(grp_stall), 64'h1);
    check("R10", "row0 held", 64'(cseq(0)), 64'd100);
    @(negedge clk);
    clear_in();
    check("R11", "stalled group no redirect", 64'(sq_valid), 64'h0);
    check("R11", "stalled group no count", 64'(cnt_taken_wrong), 64'd2);
    check("R10", "row0 still held", 64'(cseq(3)), 64'd103);
    cm_hold = 1'b0;
    #1 check("R10", "release shows row0", 64'(cseq(0)), 64'd100);
    for (int r = 1; r < T; r++) begin
      @(negedge clk);
      check("R9", "drain order", 64'(cseq(0)), 64'(100 + 4*r));
    end
    @(negedge clk);
    check("R11", "stalled group never stored", 64'(cm_valid), 64'h0);
    drain();
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_total++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    clear_in();
    cm_hold = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fu_limit();
    t_gap();
    t_squashed_free();
    t_branch();
    t_first_only();
    t_viol();
    t_pack();
    t_hold_stall();
    finish_run();
  end
endmodule